// File: doc/BRIEF.md
# Pixel Word Cache RAM Controller

This controller sits between a line-drawing engine and a video memory that is 16 bits wide. Each memory word holds a 4x4 tile of one-bit pixels. The controller keeps exactly one such word cached in a register, together with the tile address it came from. The drawing engine sends single-pixel operations as X/Y coordinates plus a pen code. When the pixel lies in the cached tile, the controller changes one bit in place. When it does not, the controller first writes the cached word back, then fetches the word that holds the requested tile, and then applies the pen to that word.

A flush command writes the cached word back without changing it, so the engine can make memory consistent at the end of a drawing. The engine sees a single ready signal. It may present a command only while ready is high, and ready stays low until the controller has finished the command. The memory side has an address, a write-data bus, a one-cycle write strobe and read data that arrives one cycle after the address.

Top module: `pixel_word_cache`

## Requirements
- R1: While reset is asserted and after it is released, ready is high and the write strobe is low. After reset the cached tile address is 0 and the cached word is 0, so a flush as the first command writes 0x0000 to address 0.
- R2: The tile address is {Y[5:2], X[5:2]}, with the Y tile bits as the upper nibble. The pixel bit inside the word is Y[1:0]*4 + X[1:0], and bit 0 is the least significant bit of the data bus.
- R3: Pen code 00 clears the selected pixel, 01 sets it and 10 inverts it. Code 11 leaves the word unchanged. No pen code touches any other bit.
- R4: A draw command whose tile address equals the cached address holds ready low for exactly one cycle and issues no memory write.
- R5: A draw command to a different tile holds ready low for exactly three cycles. In the first of them it writes the old cached word to the old address with a single strobe. It then reads the new tile's word and caches that word with the pen applied.
- R6: A flush holds ready low for exactly one cycle, issues one write of the cached word to the cached address, and leaves the cached tile and word unchanged.
- R7: If draw and flush are presented together, only the flush is carried out and the pixel is not drawn.
- R8: Draw and flush inputs presented while ready is low are ignored. They cause no write and no change to the cached word.
- R9: The write strobe is never high for two consecutive cycles and is never high while ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| px_x | input | 6 | Pixel X coordinate |
| px_y | input | 6 | Pixel Y coordinate |
| pen | input | 2 | Pen code: 00 clear, 01 set, 10 invert, 11 no change |
| draw_req | input | 1 | Draw one pixel; taken when ready is high |
| flush_req | input | 1 | Write the cached word back; wins over draw_req |
| ready | output | 1 | Controller idle and able to take a command |
| ram_addr | output | 8 | Video memory word address |
| ram_wdata | output | 16 | Video memory write data |
| ram_we | output | 1 | Video memory write strobe, one cycle |
| ram_rdata | input | 16 | Video memory read data, valid one cycle after the address |

## Verification
The cached word has no port of its own. Its contents can only be seen when they leave on a write-back. For that reason the stimulus follows each group of draws with a flush or with a miss, and it later returns to a tile it evicted earlier. That return shows both that the evicted word reached memory and that the fetched word was merged correctly. Ignored commands are the other hard case. The stimulus raises draw and flush during the write and read cycles of a miss, then drops them before the controller goes idle. A later flush then shows that no extra write took place and that the word was not touched.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_READ   = 2'd2,
    ST_UPDATE = 2'd3
  } pwc_state_e;

  typedef enum logic [1:0] {
    PEN_CLR = 2'b00,
    PEN_SET = 2'b01,
    PEN_INV = 2'b10,
    PEN_NOP = 2'b11
  } pwc_pen_e;
endpackage

// File: rtl/pwc_rst_sync.sv
module pwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], 1'b1} >> 0;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic draw_req,
  input  logic flush_req,
  input  logic tile_hit,
  output logic ready,
  output logic accept,
  output logic ram_we,
  output logic rd_phase,
  output logic upd_en,
  output logic upd_fill
);
  pwc_state_e state_q, state_d;
  logic       flush_q;
  logic       miss_q;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready & (draw_req | flush_req);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (flush_req)     state_d = ST_WRITE;
        else if (draw_req) state_d = tile_hit ? ST_UPDATE : ST_WRITE;
      end
      ST_WRITE:  state_d = flush_q ? ST_IDLE : ST_READ;
      ST_READ:   state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      miss_q  <= 1'b0;
    end else if (accept) begin
      flush_q <= flush_req;
      miss_q  <= ~flush_req & ~tile_hit;
    end
  end

  assign ram_we   = (state_q == ST_WRITE);
  assign rd_phase = (state_q == ST_READ);
  assign upd_en   = (state_q == ST_UPDATE);
  assign upd_fill = miss_q;

  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);
  // R9
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !ready);
  // R6
  flush_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && flush_q) |=> ready);
  // R5
  miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !flush_q) |=> (rd_phase && !ram_we));
  // R5
  read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> (upd_en && upd_fill));
  // R4
  hit_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !flush_req && tile_hit) |=> (upd_en && !upd_fill && !ram_we));
  // R7
  flush_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && flush_req) |=> (ram_we && !upd_en));
endmodule

// File: rtl/pwc_tile.sv
module pwc_tile
  import pwc_pkg::*;
#(
  parameter int COORD_W = 6,
  parameter int SUB_W   = 2,
  localparam int TILE_W = COORD_W - SUB_W,
  localparam int ADDR_W = 2 * TILE_W,
  localparam int BIT_W  = 2 * SUB_W,
  localparam int WORD_W = 1 << BIT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [1:0]         pen,
  input  logic               accept,
  input  logic               rd_phase,
  input  logic               upd_en,
  input  logic               upd_fill,
  input  logic [WORD_W-1:0]  ram_rdata,
  output logic               tile_hit,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [WORD_W-1:0]  ram_wdata
);
  logic [ADDR_W-1:0] live_addr;
  logic [ADDR_W-1:0] pend_addr;
  logic [BIT_W-1:0]  pend_bit;
  pwc_pen_e          pend_pen;
  logic [ADDR_W-1:0] cache_addr;
  logic [WORD_W-1:0] cache_data;
  logic [WORD_W-1:0] base_word;
  logic [WORD_W-1:0] merged;

  assign live_addr = {px_y[COORD_W-1:SUB_W], px_x[COORD_W-1:SUB_W]};
  assign tile_hit  = (live_addr == cache_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pend_bit  <= '0;
      pend_pen  <= PEN_NOP;
    end else if (accept) begin
      pend_addr <= live_addr;
      pend_bit  <= {px_y[SUB_W-1:0], px_x[SUB_W-1:0]};
      pend_pen  <= pwc_pen_e'(pen);
    end
  end

  assign base_word = upd_fill ? ram_rdata : cache_data;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign merged[i] = (pend_bit != BIT_W'(i)) ? base_word[i] :
                       (pend_pen == PEN_CLR)   ? 1'b0 :
                       (pend_pen == PEN_SET)   ? 1'b1 :
                       (pend_pen == PEN_INV)   ? ~base_word[i] :
                                                 base_word[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cache_addr <= '0;
      cache_data <= '0;
    end else if (upd_en) begin
      cache_addr <= pend_addr;
      cache_data <= merged;
    end
  end

  assign ram_addr  = rd_phase ? pend_addr : cache_addr;
  assign ram_wdata = cache_data;

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cache_addr));
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(cache_data));
  // R3
  nop_pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_fill && pend_pen == PEN_NOP) |=> $stable(cache_data));
  // R3
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_fill) |=> ($countones(cache_data ^ $past(cache_data)) <= 1));
endmodule

// File: rtl/pixel_word_cache.sv
module pixel_word_cache #(
  parameter int COORD_W = 6,
  parameter int SUB_W   = 2,
  localparam int ADDR_W = 2 * (COORD_W - SUB_W),
  localparam int WORD_W = 1 << (2 * SUB_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  logic [1:0]         pen,
  input  logic               draw_req,
  input  logic               flush_req,
  output logic               ready,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic [WORD_W-1:0]  ram_wdata,
  output logic               ram_we,
  input  logic [WORD_W-1:0]  ram_rdata
);
  logic rst_n_i;
  logic accept, tile_hit, rd_phase, upd_en, upd_fill;

  pwc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pwc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .draw_req  (draw_req),
    .flush_req (flush_req),
    .tile_hit  (tile_hit),
    .ready     (ready),
    .accept    (accept),
    .ram_we    (ram_we),
    .rd_phase  (rd_phase),
    .upd_en    (upd_en),
    .upd_fill  (upd_fill)
  );

  pwc_tile #(.COORD_W(COORD_W), .SUB_W(SUB_W)) u_tile (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .px_x      (px_x),
    .px_y      (px_y),
    .pen       (pen),
    .accept    (accept),
    .rd_phase  (rd_phase),
    .upd_en    (upd_en),
    .upd_fill  (upd_fill),
    .ram_rdata (ram_rdata),
    .tile_hit  (tile_hit),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  // R1
  reset_ready_chk: assert property (@(posedge clk)
    !rst_n_i |-> (ready && !ram_we));
endmodule

// File: tb/pixel_word_cache_tb.sv
`timescale 1ns/1ps
module pixel_word_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  px_x = '0, px_y = '0;
  logic [1:0]  pen = '0;
  logic        draw_req = 1'b0, flush_req = 1'b0;
  logic        ready, ram_we;
  logic [7:0]  ram_addr;
  logic [15:0] ram_wdata, ram_rdata;

  always #2.5 clk = ~clk;

  pixel_word_cache u_dut (
    .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y), .pen(pen),
    .draw_req(draw_req), .flush_req(flush_req), .ready(ready),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata)
  );

  // memory model: synchronous, one-cycle read latency
  logic [15:0] mem [256];
  logic [15:0] rd_q;
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    rd_q <= mem[ram_addr];
  end
  assign ram_rdata = rd_q;

  int          wcnt = 0;
  logic [7:0]  w_addr;
  logic [15:0] w_data;
  always @(posedge clk) if (ram_we) begin
    wcnt   <= wcnt + 1;
    w_addr <= ram_addr;
    w_data <= ram_wdata;
  end

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // requirement-level expectation
  logic [15:0] emem [256];
  logic [7:0]  e_addr = '0;
  logic [15:0] e_data = '0;
  int          e_busy, e_w;
  logic [7:0]  e_waddr;
  logic [15:0] e_wdata;
  string       e_tag;

  function automatic logic [15:0] pen_apply(logic [15:0] w, logic [3:0] b, logic [1:0] p);
    logic [15:0] r = w;
    case (p)
      2'b00: r[b] = 1'b0;
      2'b01: r[b] = 1'b1;
      2'b10: r[b] = ~w[b];
      default: r = w;
    endcase
    return r;
  endfunction

  task automatic model(int kind, logic [5:0] x, logic [5:0] y, logic [1:0] p);
    logic [7:0] na = {y[5:2], x[5:2]};   // R2
    logic [3:0] bi = {y[1:0], x[1:0]};
    if (kind != 0) begin                 // R6 / R7
      e_w = 1; e_waddr = e_addr; e_wdata = e_data; emem[e_addr] = e_data;
      e_busy = 1; e_tag = (kind == 2) ? "R7" : "R6";
    end else if (na == e_addr) begin     // R4
      e_w = 0; e_busy = 1; e_data = pen_apply(e_data, bi, p); e_tag = "R4";
    end else begin                       // R5
      e_w = 1; e_waddr = e_addr; e_wdata = e_data; emem[e_addr] = e_data;
      e_addr = na; e_data = pen_apply(emem[na], bi, p); e_busy = 3; e_tag = "R5";
    end
  endtask

  task automatic run_op(int kind, logic [5:0] x, logic [5:0] y, logic [1:0] p);
    int w0 = wcnt;
    int busy = 0;
    model(kind, x, y, p);
    @(negedge clk);
    px_x = x; px_y = y; pen = p;
    draw_req = (kind != 1); flush_req = (kind != 0);
    @(negedge clk);
    draw_req = 1'b0; flush_req = 1'b0;
    while (!ready && busy < 20) begin busy++; @(negedge clk); end
    chk(busy == e_busy, e_tag, busy, e_busy);
    chk((wcnt - w0) == e_w, e_tag, wcnt - w0, e_w);
    if (e_w == 1) begin
      chk(w_addr == e_waddr, e_tag, w_addr, e_waddr);   // R2 address packing
      chk(w_data == e_wdata, e_tag, w_data, e_wdata);   // R3 pen results
    end
  endtask

  // {kind[1:0], pen[1:0], y[5:0], x[5:0]}; kind 0 draw, 1 flush, 2 both
  localparam logic [15:0] VEC [15] = '{
    {2'd0, 2'b01, 6'd0,  6'd1 },
    {2'd0, 2'b01, 6'd3,  6'd3 },
    {2'd0, 2'b10, 6'd0,  6'd1 },
    {2'd1, 2'b00, 6'd0,  6'd0 },
    {2'd0, 2'b00, 6'd22, 6'd9 },
    {2'd0, 2'b11, 6'd21, 6'd10},
    {2'd0, 2'b10, 6'd23, 6'd11},
    {2'd2, 2'b01, 6'd0,  6'd0 },
    {2'd0, 2'b01, 6'd63, 6'd63},
    {2'd0, 2'b10, 6'd60, 6'd60},
    {2'd0, 2'b01, 6'd0,  6'd4 },
    {2'd0, 2'b00, 6'd2,  6'd7 },
    {2'd1, 2'b00, 6'd0,  6'd0 },
    {2'd0, 2'b01, 6'd22, 6'd9 },
    {2'd1, 2'b00, 6'd0,  6'd0 }
  };

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 40503 + 4660) ^ 16'(i << 7);
      emem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk(ready == 1'b1, "R1", ready, 1);
    chk(ram_we == 1'b0, "R1", ram_we, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", ready, 1);
    // R1: first flush writes the reset word to address 0
    run_op(1, 6'd0, 6'd0, 2'b00);

    for (int k = 0; k < 15; k++)
      run_op(int'(VEC[k][15:14]), VEC[k][5:0], VEC[k][11:6], VEC[k][13:12]);

    // R8: draw and flush held during a miss's write and read cycles
    begin
      int w0, busy;
      model(0, 6'd40, 6'd8, 2'b01);
      w0 = wcnt;
      @(negedge clk);
      px_x = 6'd40; px_y = 6'd8; pen = 2'b01; draw_req = 1'b1;
      @(negedge clk);
      px_x = 6'd1; px_y = 6'd1; pen = 2'b10; draw_req = 1'b1; flush_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      draw_req = 1'b0; flush_req = 1'b0;
      busy = 2;
      while (!ready && busy < 20) begin busy++; @(negedge clk); end
      chk(busy == 3, "R8", busy, 3);
      chk((wcnt - w0) == 1, "R8", wcnt - w0, 1);
      run_op(1, 6'd0, 6'd0, 2'b00);   // R8: word shows no trace of ignored input
    end

    // R1: reset during operation returns the cached state to zero
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready == 1'b1 && ram_we == 1'b0, "R1", {ready, ram_we}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e_addr = '0; e_data = '0;
    run_op(1, 6'd0, 6'd0, 2'b00);

    // R5: all write-backs landed where expected
    begin
      int nm = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) nm++;
      chk(nm == 0, "R5", nm, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule